// File: doc/BRIEF.md
# Firmware Block Download Receiver

This block sits on the board side of a host link and takes in a firmware image as a stream of bytes cut into fixed-size blocks. The first block carries a small header: a magic byte, the number of blocks that still follow, the expected 16-bit checksum and a three-part version number. The receiver checks the magic byte and counts the remaining blocks. It folds every image byte, except the two checksum bytes, into a running CRC. After the final byte it places a single verdict byte on its return stream.

The byte input and the verdict output are both valid/ready streams. The version fields of the most recent accepted header appear on dedicated outputs. A per-block cycle counter aborts a download that stalls for too long. The first block is allowed a longer limit than the blocks after it. An aborted download sends no verdict, and the next byte starts a fresh image.

Top module: `dlrx_loader`

## Requirements
- R1: An image is `(F+1)*BLOCK_BYTES` bytes, where F is the follow count. The verdict becomes valid in the cycle after the last byte is accepted and is never valid before that byte.
- R2: If byte 0 of an image is not 0x3C, the block answers 0x5A in the next cycle and drops the image. The version outputs keep their values, and the byte after the handshake starts a new image.
- R3: Byte 1 of the first block gives F, the number of further blocks (0 to 255). The verdict waits until all of them have arrived.
- R4: The expected CRC is carried in bytes 2 (low half) and 3 (high half) of the first block.
- R5: The CRC is CRC-16 with polynomial 0x1021, start value 0xFFFF, most significant bit first and no final inversion. It is computed over every image byte in stream order, except bytes 2 and 3 of the first block.
- R6: The verdict is 0xC3 when the computed CRC equals the expected CRC and 0x5A otherwise.
- R7: Bytes 4, 5 and 6 of the first block appear on `fw_version`, `fw_revision` and `fw_subrev`. They change only when such a byte is accepted.
- R8: While the verdict is valid it holds its value until `out_ready`, and `in_ready` stays low.
- R9: If the first block is not complete `FIRST_TMO_CYC` cycles after its first byte, the download is aborted without a verdict. A stall that is longer than `NEXT_TMO_CYC` but within the first-block limit does not abort.
- R10: If a later block is not complete `NEXT_TMO_CYC` cycles after the previous block ended, the download is aborted without a verdict.
- R11: After reset, `out_valid` is 0, `in_ready` is 1 and all version outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Image byte offered |
| in_data | input | 8 | Image byte |
| in_ready | output | 1 | Receiver takes the offered byte |
| out_valid | output | 1 | Verdict byte present |
| out_data | output | 8 | Verdict code (0xC3 or 0x5A) |
| out_ready | input | 1 | Host takes the verdict |
| fw_version | output | 8 | Version from header byte 4 |
| fw_revision | output | 8 | Revision from header byte 5 |
| fw_subrev | output | 8 | Sub-revision from header byte 6 |

## Verification
The bench probes the few places where a design that counts or orders things wrongly gives itself away. Swapping the two checksum bytes must turn a good image into 0x5A; a design that reads them high byte first would instead pass an image whose checksum is stored the wrong way round. Multi-block images check that no verdict appears one byte early, and that a design which miscounts the follow field produces no verdict or a premature one. Stalls are placed between the two timeout limits: a design that applies the short limit to the first block aborts a valid image, and one that never times out merges the next image into the dead one and answers with the wrong code.

// File: rtl/dlrx_pkg.sv
package dlrx_pkg;
  localparam logic [7:0]  HDR_MAGIC    = 8'h3C;
  localparam logic [7:0]  VERDICT_PASS = 8'hC3;
  localparam logic [7:0]  VERDICT_FAIL = 8'h5A;
  localparam logic [15:0] CRC_SEED     = 16'hFFFF;
  localparam logic [15:0] CRC_POLY     = 16'h1021;

  typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_SEND} rx_state_e;

  // one byte through the CRC, MSB first
  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int i = 0; i < 8; i++)
      r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    return r;
  endfunction
endpackage

// File: rtl/dlrx_crc16.sv
module dlrx_crc16
  import dlrx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        en,
  input  logic [7:0]  data,
  output logic [15:0] crc_nx
);
  logic [15:0] crc_q;

  assign crc_nx = crc_byte(start ? CRC_SEED : crc_q, data);

  always_ff @(posedge clk) begin
    if (rst)     crc_q <= CRC_SEED;
    else if (en) crc_q <= crc_nx;
  end
endmodule

// File: rtl/dlrx_blk_timer.sv
module dlrx_blk_timer #(
  parameter int unsigned FIRST_CYC = 1000,
  parameter int unsigned NEXT_CYC  = 100,
  parameter int unsigned CW        = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          restart,
  input  logic          first,
  output logic          expired,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] limit;

  assign limit   = first ? CW'(FIRST_CYC) : CW'(NEXT_CYC);
  assign expired = run && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run || restart) cnt <= '0;
    else if (!expired)          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dlrx_verdict_reg.sv
module dlrx_verdict_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] code,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [7:0] out_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= 8'h00;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= code;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dlrx_loader.sv
module dlrx_loader
  import dlrx_pkg::*;
#(
  parameter int unsigned BLOCK_BYTES   = 512,
  parameter int unsigned FIRST_TMO_CYC = 50_000_000,
  parameter int unsigned NEXT_TMO_CYC  = 5_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready,
  output logic [7:0] fw_version,
  output logic [7:0] fw_revision,
  output logic [7:0] fw_subrev
);
  localparam int unsigned IW     = $clog2(BLOCK_BYTES);
  localparam int unsigned TMO_MX = (FIRST_TMO_CYC > NEXT_TMO_CYC) ? FIRST_TMO_CYC : NEXT_TMO_CYC;
  localparam int unsigned TMR_W  = $clog2(TMO_MX + 1);

  rx_state_e      state;
  logic [IW-1:0]  idx;
  logic           first_blk;
  logic [7:0]     blocks_left;
  logic [7:0]     more_hdr;
  logic [15:0]    crc_expect;
  logic [15:0]    crc_nx;
  logic [TMR_W-1:0] tmr_cnt;
  logic           tmo_expired;

  logic take, at_start, in_recv, last_byte, magic_bad, crc_field, is_final;
  logic [7:0] nxt_left;
  logic       vd_load;
  logic [7:0] vd_code;

  assign in_ready  = (state != ST_SEND) && !tmo_expired;
  assign take      = in_valid && in_ready;
  assign at_start  = (state == ST_IDLE);
  assign in_recv   = (state == ST_RECV);
  assign last_byte = in_recv && (idx == IW'(BLOCK_BYTES - 1));
  assign magic_bad = (in_data != HDR_MAGIC);
  assign crc_field = first_blk && ((idx == IW'(2)) || (idx == IW'(3)));
  assign nxt_left  = first_blk ? more_hdr : (blocks_left - 8'd1);
  assign is_final  = (nxt_left == 8'd0);

  assign vd_load = take && ((at_start && magic_bad) || (last_byte && is_final));
  assign vd_code = (at_start || (crc_nx != crc_expect)) ? VERDICT_FAIL : VERDICT_PASS;

  dlrx_crc16 u_crc (
    .clk    (clk),
    .rst    (rst),
    .start  (at_start),
    .en     (take && !(in_recv && crc_field)),
    .data   (in_data),
    .crc_nx (crc_nx)
  );

  dlrx_blk_timer #(
    .FIRST_CYC (FIRST_TMO_CYC),
    .NEXT_CYC  (NEXT_TMO_CYC),
    .CW        (TMR_W)
  ) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .run     (in_recv),
    .restart (take && last_byte),
    .first   (first_blk),
    .expired (tmo_expired),
    .cnt     (tmr_cnt)
  );

  dlrx_verdict_reg u_vd (
    .clk       (clk),
    .rst       (rst),
    .load      (vd_load),
    .code      (vd_code),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      idx         <= '0;
      first_blk   <= 1'b0;
      blocks_left <= 8'd0;
      more_hdr    <= 8'd0;
      crc_expect  <= 16'h0000;
      fw_version  <= 8'h00;
      fw_revision <= 8'h00;
      fw_subrev   <= 8'h00;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (take) begin
            if (magic_bad) begin
              state <= ST_SEND;
            end else begin
              state     <= ST_RECV;
              idx       <= IW'(1);
              first_blk <= 1'b1;
            end
          end
        end
        ST_RECV: begin
          if (tmo_expired) begin
            state     <= ST_IDLE;
            idx       <= '0;
            first_blk <= 1'b0;
          end else if (take) begin
            if (first_blk) begin
              if (idx == IW'(1)) more_hdr         <= in_data;
              if (idx == IW'(2)) crc_expect[7:0]  <= in_data;
              if (idx == IW'(3)) crc_expect[15:8] <= in_data;
              if (idx == IW'(4)) fw_version       <= in_data;
              if (idx == IW'(5)) fw_revision      <= in_data;
              if (idx == IW'(6)) fw_subrev        <= in_data;
            end
            if (last_byte) begin
              idx         <= '0;
              first_blk   <= 1'b0;
              blocks_left <= nxt_left;
              if (is_final) state <= ST_SEND;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_SEND: begin
          if (out_valid && out_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dlrx_loader_chk.sv
module dlrx_loader_chk #(
  parameter int unsigned FIRST_TMO_CYC = 1000,
  parameter int unsigned TMR_W         = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic [7:0]       out_data,
  input logic             out_ready,
  input logic [7:0]       fw_version,
  input logic [7:0]       fw_revision,
  input logic [7:0]       fw_subrev,
  input logic [TMR_W-1:0] tmr_cnt
);
  AST_VERDICT_CODE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data == 8'hC3 || out_data == 8'h5A)); // R6

  AST_VERDICT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

  AST_INPUT_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready); // R8

  AST_VERDICT_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready)); // R1

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
    tmr_cnt <= TMR_W'(FIRST_TMO_CYC)); // R9

  AST_VERSION_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable({fw_version, fw_revision, fw_subrev})); // R7
endmodule

bind dlrx_loader dlrx_loader_chk #(
  .FIRST_TMO_CYC (FIRST_TMO_CYC),
  .TMR_W         (TMR_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .out_ready   (out_ready),
  .fw_version  (fw_version),
  .fw_revision (fw_revision),
  .fw_subrev   (fw_subrev),
  .tmr_cnt     (tmr_cnt)
);

// File: tb/dlrx_loader_test.sv
module dlrx_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam int BLK        = 512;
  localparam int FT         = 2500;
  localparam int NT         = 1000;

  // {follow count, seed, mode (0 good, 1 flipped crc, 2 swapped crc bytes), expected verdict}
  localparam logic [31:0] VEC [5] = '{
    32'h00_11_00_C3,
    32'h02_22_00_C3,
    32'h01_33_01_5A,
    32'h00_44_02_5A,
    32'h03_55_00_C3
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ready = 1'b0;
  logic [7:0] fw_version, fw_revision, fw_subrev;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dlrx_loader #(.BLOCK_BYTES(BLK), .FIRST_TMO_CYC(FT), .NEXT_TMO_CYC(NT)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .fw_version(fw_version), .fw_revision(fw_revision), .fw_subrev(fw_subrev)
  );

  // serial reference CRC, one bit at a time
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int b = 7; b >= 0; b--) begin
      fb = r[15] ^ d[b];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  function automatic logic [7:0] img_byte(input logic [7:0] seed, input logic [7:0] more, input int p);
    if (p == 0) return 8'h3C;
    if (p == 1) return more;
    if (p == 4) return seed;
    if (p == 5) return seed ^ 8'hFF;
    if (p == 6) return seed + 8'd1;
    if (p < 16) return 8'h00;
    if (p < 47) return 8'h30 + 8'(p % 10);
    if (p == 47) return 8'h00;
    return 8'((p * 13) ^ (p >> 5)) ^ seed;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic take_verdict();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R8", "verdict cleared after handshake", 32'(out_valid), 0);
  endtask

  task automatic run_image(input logic [7:0] seed, input logic [7:0] more, input int mode,
                           input logic [7:0] expv, input int stall_pos, input int stall_len,
                           input bit truncate, input string req);
    int total;
    logic [15:0] c;
    logic [7:0] b;
    total = (int'(more) + 1) * BLK;
    c = 16'hFFFF;
    for (int p = 0; p < total; p++)
      if (p != 2 && p != 3) c = ref_crc(c, img_byte(seed, more, p));
    if (mode == 1)      c = c ^ 16'h0100;
    else if (mode == 2) c = {c[7:0], c[15:8]};
    for (int p = 0; p < total; p++) begin
      if (p == stall_pos) begin
        in_valid = 1'b0;
        repeat (stall_len) @(negedge clk);
        if (truncate) begin
          chk(out_valid == 1'b0, req, "no verdict after timeout", 32'(out_valid), 0);
          chk(in_ready == 1'b1, req, "ready after timeout", 32'(in_ready), 1);
          return;
        end
      end
      if (p == 2)      b = c[7:0];
      else if (p == 3) b = c[15:8];
      else             b = img_byte(seed, more, p);
      if (p == total - 1)
        chk(out_valid == 1'b0, "R1", "no verdict before last byte", 32'(out_valid), 0);
      send_byte(b);
    end
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R1", "verdict after last byte", 32'(out_valid), 1);
    chk(out_data == expv, req, "verdict code", 32'(out_data), 32'(expv));
    chk({fw_version, fw_revision, fw_subrev} == {seed, seed ^ 8'hFF, seed + 8'd1}, "R7",
        "version fields", 32'({fw_version, fw_revision, fw_subrev}),
        32'({seed, seed ^ 8'hFF, seed + 8'd1}));
    take_verdict();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(out_valid == 1'b0, "R11", "out_valid after reset", 32'(out_valid), 0);
    chk(in_ready == 1'b1, "R11", "in_ready after reset", 32'(in_ready), 1);
    chk({fw_version, fw_revision, fw_subrev} == 24'h0, "R11", "versions after reset",
        32'({fw_version, fw_revision, fw_subrev}), 0);

    // vector table: R3 multi-block counts, R4 byte order, R5 CRC, R6 codes
    for (int v = 0; v < 5; v++) begin
      string rq;
      int md;
      md = int'(VEC[v][15:8]);
      if (md == 2)                  rq = "R4";
      else if (md == 1)             rq = "R6";
      else if (VEC[v][31:24] != 0)  rq = "R3";
      else                          rq = "R5";
      run_image(VEC[v][23:16], VEC[v][31:24], md, VEC[v][7:0], -1, 0, 1'b0, rq);
    end

    // R2 bad magic: immediate reject, versions untouched
    send_byte(8'hA5);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R2", "reject verdict present", 32'(out_valid), 1);
    chk(out_data == 8'h5A, "R2", "reject code", 32'(out_data), 32'h5A);
    chk(in_ready == 1'b0, "R8", "input blocked during verdict", 32'(in_ready), 0);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b1 && out_data == 8'h5A, "R8", "verdict held without ready",
        32'({out_valid, out_data}), 32'h15A);
    chk(fw_version == 8'h55, "R2", "version kept after reject", 32'(fw_version), 32'h55);
    take_verdict();
    run_image(8'h61, 8'd0, 0, 8'hC3, -1, 0, 1'b0, "R2");

    // R9 stall over the later-block limit but within the first-block limit: no abort
    run_image(8'h66, 8'd0, 0, 8'hC3, 10, 1200, 1'b0, "R9");
    // R9 first block abort, then a fresh image
    run_image(8'h70, 8'd1, 0, 8'hC3, 100, 2600, 1'b1, "R9");
    run_image(8'h71, 8'd0, 0, 8'hC3, -1, 0, 1'b0, "R9");
    // R10 later block within limit
    run_image(8'h77, 8'd1, 0, 8'hC3, 600, 400, 1'b0, "R10");
    // R10 later block abort, then a fresh image
    run_image(8'h78, 8'd1, 0, 8'hC3, 522, 1200, 1'b1, "R10");
    run_image(8'h79, 8'd0, 0, 8'hC3, -1, 0, 1'b0, "R10");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule